// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character per handshake into a serial frame on a single data line. The frame layout is picked at run time. It has a start bit, then a data field of 5 to 9 bits, then an optional parity bit (even or odd), then one or two stop bits. That gives thirty layouts. The data field goes out least significant bit first, and the line rests high whenever no frame is being sent.

There are two timing modes. In asynchronous mode every bit lasts a fixed number of system clocks, set by a parameter. In synchronous master mode the block also drives a shift clock. The output data changes on one edge of that clock, and a receiver samples it on the other edge. A polarity input selects which edge is the change edge and also sets the clock's resting level.

Configuration and data are captured when a word is accepted, so they may change freely while a frame is running. If a new word is already offered when the last stop bit ends, it is accepted in that same cycle. Its start bit then follows without any idle gap.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `ser_out` is 1 and `busy` is 0. In the cycle after a word is accepted, `busy` is 1 and `ser_out` carries the start bit, whose value is 0.
- R2: `cfg_len` sets the data field length. Codes 0, 1, 2, 3 and 4 give 5, 6, 7, 8 and 9 bits. Codes 5, 6 and 7 also give 9 bits.
- R3: Data bits follow the start bit in order from bit 0 of `word_data` upward. Bits of `word_data` above the selected length are not sent.
- R4: `cfg_parity` selects the parity bit. Codes 00 and 01 insert no parity bit. Code 10 inserts even parity: the number of ones across data and parity is even. Code 11 inserts odd parity: that number is odd. The parity bit sits right after the last data bit.
- R5: The frame ends with stop bits of value 1. There is one stop bit when `cfg_two_stop` is 0 and two when it is 1.
- R6: With `cfg_sync` 0, every bit lasts ASYNC_DIV clocks. With `cfg_sync` 1, every bit lasts 2*SYNC_HALF clocks.
- R7: In synchronous mode, `sclk_out` is at the inverse of the polarity level for the first SYNC_HALF clocks of each bit and at the polarity level for the rest. With polarity 0, data therefore changes on a rising edge; with polarity 1, on a falling edge. While a synchronous frame runs, `ser_out` changes only together with an edge that leaves the polarity level.
- R8: When no frame is in progress, `sclk_out` equals the live `cfg_pol`. During an asynchronous frame it stays at the polarity level captured for that frame.
- R9: `word_ready` is 1 while idle and in the final clock of the last stop bit, and 0 at all other times during a frame. A word is taken only when `word_valid` and `word_ready` are both 1.
- R10: If `word_valid` is 1 in the final clock of the last stop bit, the next frame's start bit appears in the very next clock and `busy` does not drop.
- R11: `word_data`, `cfg_len`, `cfg_parity`, `cfg_two_stop`, `cfg_sync` and `cfg_pol` are captured at acceptance. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_data | input | DATA_W | Character to send, bit 0 sent first |
| word_valid | input | 1 | A character is offered |
| word_ready | output | 1 | The block takes a character this cycle if offered |
| cfg_len | input | 3 | Data length code (0..4 → 5..9 bits, larger codes → 9) |
| cfg_parity | input | 2 | Parity code: 0x none, 10 even, 11 odd |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_sync | input | 1 | 1 selects synchronous master mode |
| cfg_pol | input | 1 | Shift-clock polarity and resting level |
| ser_out | output | 1 | Serial data line, high when idle |
| sclk_out | output | 1 | Shift clock in synchronous mode |
| busy | output | 1 | A frame is in progress |

## Verification
The bench builds the block with ASYNC_DIV = 6 and SYNC_HALF = 2. A bit then lasts 6 clocks in asynchronous mode and 4 in synchronous mode. That keeps frames short enough to sweep every length code, parity code, stop count, mode and polarity: 256 frames, each with its own data pattern. The two bit periods differ, so a mix-up between the modes shows up as misplaced bits.

After every acceptance, the bench inverts all data and configuration inputs to prove they were captured. A chained pair of frames that switches from asynchronous to synchronous mode exercises the gap-free hand-off.

// File: rtl/sft_pkg.sv
// Shared definitions for the serial frame transmitter.
// Assumes: the parity code is two bits wide and its upper bit enables parity.
package sft_pkg;
    localparam int LEN_CODE_W = 3;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'b00,
        PAR_NONE_ALT = 2'b01,
        PAR_EVEN     = 2'b10,
        PAR_ODD      = 2'b11
    } par_e;
endpackage

// File: rtl/sft_frame_pack.sv
// Builds the whole frame as a vector to be sent from bit 0 upward, and
// reports how many bits it holds. Purely combinational.
// Assumes: DATA_W >= MIN_LEN. Positions beyond the frame are filled with 1.
module sft_frame_pack
    import sft_pkg::*;
#(
    parameter int DATA_W  = 9,
    parameter int MIN_LEN = 5,
    localparam int FW     = DATA_W + 4,
    localparam int NW     = $clog2(FW + 1)
) (
    input  logic [DATA_W-1:0]     data,
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic [1:0]            par_mode,
    input  logic                  two_stop,
    output logic [FW-1:0]         frame,
    output logic [NW-1:0]         nbits
);
    // Lay out start, data, parity and stop bits; stop bits come from the 1 fill.
    always_comb begin
        int   len;
        logic par_en;
        logic pbit;
        len = MIN_LEN + int'(len_code);
        if (len > DATA_W) len = DATA_W;
        par_en = par_mode[1];
        pbit   = (par_e'(par_mode) == PAR_ODD);
        for (int i = 0; i < DATA_W; i++) begin
            if (i < len) pbit = pbit ^ data[i];
        end
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < len)                   frame[i+1] = data[i];
            else if (i == len && par_en)   frame[i+1] = pbit;
        end
        if (len == DATA_W && par_en) frame[DATA_W+1] = pbit;
        nbits = NW'(1 + len + (par_en ? 1 : 0) + (two_stop ? 2 : 1));
    end
endmodule

// File: rtl/sft_bit_timer.sv
// Counts clocks inside one bit. It signals the last clock of the bit and
// whether the count is still in the first half of a synchronous bit.
// Assumes: ASYNC_DIV >= 2 and SYNC_HALF >= 1; restart wins over counting.
module sft_bit_timer #(
    parameter int ASYNC_DIV = 16,
    parameter int SYNC_HALF = 8,
    localparam int SYNC_P   = 2 * SYNC_HALF,
    localparam int MAXP     = (ASYNC_DIV > SYNC_P) ? ASYNC_DIV : SYNC_P,
    localparam int CW       = $clog2(MAXP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic sync_mode,
    output logic step,
    output logic first_half
);
    localparam logic [CW-1:0] LAST_ASYNC = CW'(ASYNC_DIV - 1);
    localparam logic [CW-1:0] LAST_SYNC  = CW'(SYNC_P - 1);
    localparam logic [CW-1:0] HALF_MARK  = CW'(SYNC_HALF);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_cnt;

    // Pick the final count of a bit from the mode captured for the frame.
    always_comb last_cnt = sync_mode ? LAST_SYNC : LAST_ASYNC;

    assign step       = run && (cnt == last_cnt);
    assign first_half = (cnt < HALF_MARK);

    // Advance the in-bit counter, wrapping at the end of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (run)     cnt <= step ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/serial_frame_tx.sv
// Top of the serial frame transmitter. It accepts a character through a
// valid/ready handshake, captures the format, and shifts the frame out one
// bit per bit period. In synchronous mode it also drives a shift clock.
// Assumes: the receiver samples on the edge opposite the change edge.
module serial_frame_tx
    import sft_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter int MIN_LEN   = 5,
    parameter int ASYNC_DIV = 16,
    parameter int SYNC_HALF = 8,
    localparam int FW       = DATA_W + 4,
    localparam int NW       = $clog2(FW + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W-1:0]     word_data,
    input  logic                  word_valid,
    output logic                  word_ready,
    input  logic [LEN_CODE_W-1:0] cfg_len,
    input  logic [1:0]            cfg_parity,
    input  logic                  cfg_two_stop,
    input  logic                  cfg_sync,
    input  logic                  cfg_pol,
    output logic                  ser_out,
    output logic                  sclk_out,
    output logic                  busy
);
    logic [FW-1:0] frame_new;
    logic [NW-1:0] nbits_new;
    logic [FW-1:0] shreg;
    logic [NW-1:0] left;
    logic          sync_q;
    logic          pol_q;
    logic          step;
    logic          first_half;
    logic          last_bit;
    logic          accept;
    logic          pol_now;

    sft_frame_pack #(
        .DATA_W  (DATA_W),
        .MIN_LEN (MIN_LEN)
    ) u_pack (
        .data     (word_data),
        .len_code (cfg_len),
        .par_mode (cfg_parity),
        .two_stop (cfg_two_stop),
        .frame    (frame_new),
        .nbits    (nbits_new)
    );

    sft_bit_timer #(
        .ASYNC_DIV (ASYNC_DIV),
        .SYNC_HALF (SYNC_HALF)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (accept),
        .run        (busy),
        .sync_mode  (sync_q),
        .step       (step),
        .first_half (first_half)
    );

    assign last_bit   = (left == NW'(1));
    assign word_ready = !busy || (step && last_bit);
    assign accept     = word_valid && word_ready;

    // Load a new frame on acceptance, else shift one bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            shreg  <= '1;
            left   <= '0;
            sync_q <= 1'b0;
            pol_q  <= 1'b0;
        end else if (accept) begin
            busy   <= 1'b1;
            shreg  <= frame_new;
            left   <= nbits_new;
            sync_q <= cfg_sync;
            pol_q  <= cfg_pol;
        end else if (step) begin
            shreg <= {1'b1, shreg[FW-1:1]};
            left  <= left - 1'b1;
            if (last_bit) busy <= 1'b0;
        end
    end

    // Drive the line high when idle, else the current frame bit.
    always_comb ser_out = busy ? shreg[0] : 1'b1;

    // Polarity level: captured during a frame, live while idle.
    always_comb pol_now = busy ? pol_q : cfg_pol;

    // Shift clock leaves its resting level in the first half of each synchronous bit.
    always_comb sclk_out = (busy && sync_q && first_half) ? !pol_now : pol_now;
endmodule

// File: rtl/sft_checker.sv
// Temporal checks for serial_frame_tx, attached with bind.
// Assumes: it observes the top's ports plus the captured mode and polarity.
module sft_checker (
    input logic clk,
    input logic rst_n,
    input logic word_valid,
    input logic word_ready,
    input logic ser_out,
    input logic sclk_out,
    input logic busy,
    input logic cfg_pol,
    input logic sync_q,
    input logic pol_q
);
    p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ser_out);

    p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready) |=> (busy && !ser_out));

    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> word_ready);

    p_no_early_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !word_ready) |=> busy);

    p_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && word_ready && word_valid) |=> (busy && !ser_out));

    p_sclk_rest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk_out == cfg_pol));

    p_change_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && sync_q && (ser_out != $past(ser_out)))
            |-> (sclk_out == !pol_q));
endmodule

bind serial_frame_tx sft_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .ser_out    (ser_out),
    .sclk_out   (sclk_out),
    .busy       (busy),
    .cfg_pol    (cfg_pol),
    .sync_q     (sync_q),
    .pol_q      (pol_q)
);

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;
    localparam int DW   = 9;
    localparam int DIV  = 6;
    localparam int HALF = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] word_data = '0;
    logic          word_valid = 1'b0;
    logic          word_ready;
    logic [2:0]    cfg_len = '0;
    logic [1:0]    cfg_parity = '0;
    logic          cfg_two_stop = 1'b0;
    logic          cfg_sync = 1'b0;
    logic          cfg_pol = 1'b1;
    logic          ser_out;
    logic          sclk_out;
    logic          busy;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    serial_frame_tx #(
        .DATA_W    (DW),
        .MIN_LEN   (5),
        .ASYNC_DIV (DIV),
        .SYNC_HALF (HALF)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_data    (word_data),
        .word_valid   (word_valid),
        .word_ready   (word_ready),
        .cfg_len      (cfg_len),
        .cfg_parity   (cfg_parity),
        .cfg_two_stop (cfg_two_stop),
        .cfg_sync     (cfg_sync),
        .cfg_pol      (cfg_pol),
        .ser_out      (ser_out),
        .sclk_out     (sclk_out),
        .busy         (busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int len_of(input logic [2:0] code);
        int l = 5 + int'(code);
        return (l > 9) ? 9 : l;
    endfunction

    // Expected value of frame bit k, from the requirements alone.
    function automatic logic exp_bit(input int k, input logic [DW-1:0] d,
                                     input logic [2:0] lc, input logic [1:0] pm);
        int   l = len_of(lc);
        logic p = pm[0];
        for (int i = 0; i < l; i++) p = p ^ d[i];
        if (k == 0) return 1'b0;
        if (k <= l) return d[k-1];
        if (pm[1] && k == l + 1) return p;
        return 1'b1;
    endfunction

    // Entered at the negedge right after acceptance; leaves in the frame's last clock.
    task automatic check_frame(input logic [DW-1:0] d, input logic [2:0] lc,
                               input logic [1:0] pm, input logic ts,
                               input logic sy, input logic po);
        int n = 1 + len_of(lc) + (pm[1] ? 1 : 0) + (ts ? 2 : 1);
        int per = sy ? 2 * HALF : DIV;
        for (int c = 0; c < n * per; c++) begin
            int k = c / per;
            int j = c % per;
            logic es;
            if (c > 0) @(negedge clk);
            if (c == 0) chk(busy && !ser_out, "R1", "start bit/busy", {busy, ser_out}, 2);
            if (j == per / 2) begin
                logic eb = exp_bit(k, d, lc, pm);
                string rq = (k == 0) ? "R1" : (k <= len_of(lc)) ? "R3" :
                            (pm[1] && k == len_of(lc) + 1) ? "R4" : "R5";
                chk(ser_out == eb, rq, $sformatf("bit %0d", k), ser_out, eb);
            end
            if (j == 0 && c > 0) chk(busy == 1'b1, "R6", "busy inside frame", busy, 1);
            es = (sy && j < HALF) ? !po : po;
            chk(sclk_out == es, sy ? "R7" : "R8", "sclk level", sclk_out, es);
            if (c == n * per - 1) chk(word_ready == 1'b1, "R9", "ready last clock", word_ready, 1);
            else chk(word_ready == 1'b0, "R9", "ready mid frame", word_ready, 0);
        end
    endtask

    task automatic apply(input logic [DW-1:0] d, input logic [2:0] lc,
                         input logic [1:0] pm, input logic ts,
                         input logic sy, input logic po);
        word_data = d; cfg_len = lc; cfg_parity = pm;
        cfg_two_stop = ts; cfg_sync = sy; cfg_pol = po;
    endtask

    // Send one frame, scramble all inputs after acceptance (R11), check, then idle.
    task automatic one_frame(input logic [DW-1:0] d, input logic [2:0] lc,
                             input logic [1:0] pm, input logic ts,
                             input logic sy, input logic po);
        @(negedge clk);
        apply(d, lc, pm, ts, sy, po);
        word_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        word_valid = 1'b0;
        apply(~d, ~lc, ~pm, ~ts, ~sy, ~po);
        check_frame(d, lc, pm, ts, sy, po);
        @(negedge clk);
        chk(!busy && ser_out, "R1", "idle after frame", {busy, ser_out}, 1);
        chk(sclk_out == cfg_pol, "R8", "idle sclk follows live polarity", sclk_out, cfg_pol);
        chk(word_ready == 1'b1, "R9", "ready when idle", word_ready, 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state (R1, R8, R9)
        chk(ser_out == 1'b1, "R1", "reset line", ser_out, 1);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(sclk_out == 1'b1, "R8", "reset sclk rest", sclk_out, 1);
        chk(word_ready == 1'b1, "R9", "reset ready", word_ready, 1);
        rst_n = 1'b1;

        // Full sweep of formats and modes (R2..R8, R11)
        for (int sy = 0; sy < 2; sy++)
            for (int po = 0; po < 2; po++)
                for (int lc = 0; lc < 8; lc++)
                    for (int pm = 0; pm < 4; pm++)
                        for (int ts = 0; ts < 2; ts++) begin
                            logic [DW-1:0] d = DW'((idx * 37 + 346) ^ (idx << 3));
                            one_frame(d, 3'(lc), 2'(pm), 1'(ts), 1'(sy), 1'(po));
                            idx++;
                        end

        // Back-to-back: async frame, then a sync frame with no gap (R10, R11)
        @(negedge clk);
        apply(9'h0A5, 3'd3, 2'b10, 1'b0, 1'b0, 1'b0);
        word_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        apply(9'h153, 3'd0, 2'b11, 1'b1, 1'b1, 1'b1);
        check_frame(9'h0A5, 3'd3, 2'b10, 1'b0, 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        word_valid = 1'b0;
        chk(busy && !ser_out, "R10", "next start bit without gap", {busy, ser_out}, 2);
        check_frame(9'h153, 3'd0, 2'b11, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        chk(!busy && ser_out, "R10", "idle after chained pair", {busy, ser_out}, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule